// File: doc/BRIEF.md
# Snooping Cache Coherence Controller

This block is the coherence engine of one processor's private, direct-mapped cache on a shared snooping bus. Every line holds a tag, one data word and a coherence state (Invalid, Shared, Modified, and Exclusive when the clean-exclusive option is built in). Two sources change a line's state. Local processor requests arrive on a valid/ready port: hits complete at once, and misses or upgrades stall the processor. Transactions from other caches are watched on the snoop inputs and can downgrade or drop a line, with the dirty word written back when needed.

Towards the bus the block raises a request, waits for an external arbiter's grant, and then places a 2-bit command with address and requester ID on the bus for exactly the grant cycle. Line data comes back from the memory side on a fill strobe, together with the wired-OR "another cache holds this line" flag. Dirty words leave on a single write-back strobe. That strobe is shared between snoop-forced write-backs and eviction of a Modified victim, and the memory side must accept it in the cycle it is shown.

Back-pressure on the processor port: a request is taken in the cycle where `cpu_req_valid` and `cpu_req_ready` are both high. `cpu_req_ready` may depend on `cpu_req_valid`. While a request is stalled, the master must keep it valid and leave address, write flag and write data unchanged. For a read, `cpu_rdata` is valid in the accepting cycle only.

Top module: `mcc_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid. The block raises no bus request and no write-back. A snoop of any address reports no copy, and the first access to any address is a miss.
- R2: A read that hits a Shared, Exclusive or Modified line is accepted in the cycle it is presented. It returns the line's word and places no command on the bus.
- R3: A read miss places the read-miss command (code 01) on the bus in the grant cycle, with the request address and this cache's ID. After the fill the request completes with the filled word, and the line is Shared whenever the fill reports another sharer.
- R4: A write that hits a Shared line places the invalidate command (code 11) on the bus. The write then completes and the line becomes Modified, so a further write to it causes no bus command.
- R5: A write that hits a Modified line completes in the cycle it is presented, with no bus command and no write-back.
- R6: A write miss places the write-miss command (code 10) on the bus. The line is filled and then overwritten with the write data, and the line is Modified.
- R7: A miss whose victim line is Modified first writes the victim's word back at the victim's own address, and only then issues the miss command. A victim that is Shared or Exclusive is dropped with no write-back.
- R8: A snooped read-miss that matches a Modified line drives a write-back of the line's word in the same cycle and leaves the line Shared.
- R9: A snooped read-miss that matches a Shared line changes nothing and causes no write-back. The shared-line response is raised for any snoop that matches a valid line.
- R10: A snooped write-miss or invalidate that matches a line makes it Invalid. If the line was Modified, its word is written back in the same cycle.
- R11: A snoop takes priority: while a snoop from another cache is on the inputs, no processor request is accepted. Snoops carrying this cache's own ID are ignored.
- R12: With the clean-exclusive option enabled, a read fill that reports no other sharer leaves the line Exclusive. A later write hit then moves it to Modified with no bus command, and a snooped read-miss moves it to Shared with no write-back. With the option disabled, no line is ever Exclusive.
- R13: Once raised, the bus request stays high until granted (an upgrade whose line was lost meanwhile may withdraw it). A command other than idle appears only in a grant cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Request accepted this cycle |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address (low IDX_W bits index the line) |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with an accepted read |
| bus_req | output | 1 | Request for bus ownership |
| bus_gnt | input | 1 | Grant from external arbiter |
| bus_cmd | output | 2 | 00 idle, 01 read-miss, 10 write-miss, 11 invalidate |
| bus_addr | output | ADDR_W | Address of the issued command |
| bus_id | output | ID_W | This cache's ID |
| fill_valid | input | 1 | Fill word present |
| fill_data | input | DATA_W | Fill word |
| fill_shared | input | 1 | Wired-OR: another cache holds the filled line |
| snp_cmd | input | 2 | Snooped command, same coding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_id | input | ID_W | Requester ID of the snooped command |
| snp_hit_shared | output | 1 | This cache holds a valid copy of the snooped line |
| wb_valid | output | 1 | Write-back strobe |
| wb_addr | output | ADDR_W | Write-back address |
| wb_data | output | DATA_W | Write-back word |

## Verification
The bench builds the block with four lines, ID 1 and the clean-exclusive option enabled. With only four lines, a handful of addresses is enough to force index conflicts, so dirty and clean evictions come up after a few accesses. Holding the fill's sharer flag high makes the block follow the pure three-state paths. Dropping the flag reaches the Exclusive state and its silent upgrade. A programmable grant delay in the bus model stretches the arbitration wait, which shows whether the request is held steady until the grant.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BC_IDLE   = 2'b00,
    BC_RDMISS = 2'b01,
    BC_WRMISS = 2'b10,
    BC_INVAL  = 2'b11
  } bus_cmd_t;
endpackage

// File: rtl/mcc_line_store.sv
module mcc_line_store
  import mcc_pkg::*;
#(
  parameter int LINES   = 8,
  parameter int TAG_W   = 5,
  parameter int DATA_W  = 16,
  parameter bit MESI_EN = 1'b0,
  localparam int IDX_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  // processor-side port
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_t          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic              cw_st_en,
  input  line_st_t          cw_st,
  input  logic              cw_tag_en,
  input  logic [TAG_W-1:0]  cw_tag,
  input  logic              cw_data_en,
  input  logic [DATA_W-1:0] cw_data,
  // snoop-side port
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_t          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              sw_en,
  input  line_st_t          sw_st
);
  line_st_t          st_all   [LINES];
  logic [TAG_W-1:0]  tag_all  [LINES];
  logic [DATA_W-1:0] data_all [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_t          st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;
    logic              cpu_sel, snp_sel;

    assign cpu_sel = (a_idx == IDX_W'(g));
    assign snp_sel = (b_idx == IDX_W'(g));

    // processor side wins when both ports write the same line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q <= LS_I;
      end else if (cpu_sel && cw_st_en) begin
        st_q <= cw_st;
      end else if (snp_sel && sw_en) begin
        st_q <= sw_st;
      end
    end

    always_ff @(posedge clk) begin
      if (cpu_sel && cw_tag_en)  tag_q  <= cw_tag;
      if (cpu_sel && cw_data_en) data_q <= cw_data;
    end

    assign st_all[g]   = st_q;
    assign tag_all[g]  = tag_q;
    assign data_all[g] = data_q;
  end

  assign a_st   = st_all[a_idx];
  assign a_tag  = tag_all[a_idx];
  assign a_data = data_all[a_idx];
  assign b_st   = st_all[b_idx];
  assign b_tag  = tag_all[b_idx];
  assign b_data = data_all[b_idx];

  // R12: without the clean-exclusive option no line is ever seen Exclusive
  assert_no_excl_in_msi_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (MESI_EN || (a_st != LS_E && b_st != LS_E)));
endmodule

// File: rtl/mcc_snoop_ctl.sv
module mcc_snoop_ctl
  import mcc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_id,
  output logic [IDX_W-1:0]  b_idx,
  input  line_st_t          b_st,
  input  logic [TAG_W-1:0]  b_tag,
  output logic              active,
  output logic              match,
  output logic              sw_en,
  output line_st_t          sw_st,
  output logic              wb_req
);
  bus_cmd_t cmd;

  assign cmd    = bus_cmd_t'(snp_cmd);
  assign b_idx  = snp_addr[IDX_W-1:0];
  assign active = (cmd != BC_IDLE) && (snp_id != ID_W'(MY_ID));
  assign match  = active && (b_st != LS_I) && (b_tag == snp_addr[ADDR_W-1:IDX_W]);

  always_comb begin
    sw_en  = 1'b0;
    sw_st  = b_st;
    wb_req = 1'b0;
    if (match) begin
      unique case (cmd)
        BC_RDMISS: begin
          // dirty owner supplies the word; clean owners fall back to Shared
          if (b_st == LS_M || b_st == LS_E) begin
            sw_en  = 1'b1;
            sw_st  = LS_S;
            wb_req = (b_st == LS_M);
          end
        end
        BC_WRMISS, BC_INVAL: begin
          sw_en  = 1'b1;
          sw_st  = LS_I;
          wb_req = (b_st == LS_M);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mcc_req_fsm.sv
module mcc_req_fsm
  import mcc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 3,
  parameter bit MESI_EN = 1'b0,
  localparam int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [IDX_W-1:0]  a_idx,
  input  line_st_t          a_st,
  input  logic [TAG_W-1:0]  a_tag,
  input  logic [DATA_W-1:0] a_data,
  output logic              cw_st_en,
  output line_st_t          cw_st,
  output logic              cw_tag_en,
  output logic [TAG_W-1:0]  cw_tag,
  output logic              cw_data_en,
  output logic [DATA_W-1:0] cw_data,
  input  logic              snp_active,
  output logic              bus_req,
  input  logic              bus_gnt,
  output bus_cmd_t          bus_cmd,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fill_shared,
  output logic              evict_wb,
  output logic [ADDR_W-1:0] evict_addr
);
  typedef enum logic [1:0] {P_IDLE, P_EVICT, P_ARB, P_FILL} phase_t;

  phase_t   ph_q, ph_d;
  bus_cmd_t pend_q, pend_d;

  logic [TAG_W-1:0] req_tag;
  logic             hit, owned, still_shr;

  assign a_idx     = cpu_req_addr[IDX_W-1:0];
  assign req_tag   = cpu_req_addr[ADDR_W-1:IDX_W];
  assign hit       = (a_st != LS_I) && (a_tag == req_tag);
  assign owned     = (a_st == LS_E) || (a_st == LS_M);
  assign still_shr = hit && (a_st == LS_S);
  assign cpu_rdata = a_data;
  assign evict_addr = {a_tag, a_idx};

  assign cpu_req_ready = (ph_q == P_IDLE) && cpu_req_valid && hit &&
                         (!cpu_req_write || owned) && !snp_active;

  always_comb begin
    ph_d       = ph_q;
    pend_d     = pend_q;
    cw_st_en   = 1'b0;
    cw_st      = a_st;
    cw_tag_en  = 1'b0;
    cw_tag     = req_tag;
    cw_data_en = 1'b0;
    cw_data    = cpu_req_wdata;
    bus_req    = 1'b0;
    bus_cmd    = BC_IDLE;
    evict_wb   = 1'b0;
    unique case (ph_q)
      P_IDLE: begin
        if (cpu_req_ready && cpu_req_write) begin
          cw_data_en = 1'b1;
          cw_st_en   = 1'b1;
          cw_st      = LS_M;
        end else if (cpu_req_valid && !cpu_req_ready && !snp_active) begin
          if (still_shr && cpu_req_write) begin
            pend_d = BC_INVAL;
            ph_d   = P_ARB;
          end else if (!hit) begin
            pend_d = cpu_req_write ? BC_WRMISS : BC_RDMISS;
            ph_d   = (a_st == LS_M) ? P_EVICT : P_ARB;
          end
        end
      end
      P_EVICT: begin
        if (!snp_active) begin
          if (a_st == LS_M) begin
            evict_wb = 1'b1;
            cw_st_en = 1'b1;
            cw_st    = LS_I;
          end
          ph_d = P_ARB;
        end
      end
      P_ARB: begin
        if (pend_q == BC_INVAL && !still_shr) begin
          ph_d = P_IDLE;
        end else begin
          bus_req = 1'b1;
          if (bus_gnt) begin
            bus_cmd = pend_q;
            if (pend_q == BC_INVAL) begin
              cw_st_en = 1'b1;
              cw_st    = LS_M;
              ph_d     = P_IDLE;
            end else begin
              ph_d = P_FILL;
            end
          end
        end
      end
      P_FILL: begin
        if (fill_valid) begin
          cw_tag_en  = 1'b1;
          cw_data_en = 1'b1;
          cw_data    = fill_data;
          cw_st_en   = 1'b1;
          if (pend_q == BC_WRMISS)         cw_st = LS_M;
          else if (MESI_EN && !fill_shared) cw_st = LS_E;
          else                              cw_st = LS_S;
          ph_d = P_IDLE;
        end
      end
      default: ph_d = P_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= P_IDLE;
      pend_q <= BC_IDLE;
    end else begin
      ph_q   <= ph_d;
      pend_q <= pend_d;
    end
  end

  // R2: an accepted request never coincides with a bus command
  assert_hit_no_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> (bus_cmd == BC_IDLE));

  // R13: a miss request is held until the arbiter grants it
  assert_req_held_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && pend_q != BC_INVAL) |=> bus_req);

  // R7: a dirty victim's write-back is followed by the miss request
  assert_evict_then_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evict_wb |=> bus_req);
endmodule

// File: rtl/mcc_cache_ctrl.sv
module mcc_cache_ctrl
  import mcc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int LINES   = 8,
  parameter int ID_W    = 2,
  parameter int MY_ID   = 0,
  parameter bit MESI_EN = 1'b0,
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [ID_W-1:0]   bus_id,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fill_shared,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_id,
  output logic              snp_hit_shared,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  logic [IDX_W-1:0]  a_idx, b_idx;
  line_st_t          a_st, b_st, cw_st, sw_st;
  logic [TAG_W-1:0]  a_tag, b_tag, cw_tag;
  logic [DATA_W-1:0] a_data, b_data, cw_data;
  logic              cw_st_en, cw_tag_en, cw_data_en, sw_en;
  logic              snp_active, snp_match, snp_wb, evict_wb;
  logic [ADDR_W-1:0] evict_addr;
  bus_cmd_t          cmd_out;

  mcc_line_store #(
    .LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .MESI_EN(MESI_EN)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
    .cw_st_en(cw_st_en), .cw_st(cw_st), .cw_tag_en(cw_tag_en), .cw_tag(cw_tag),
    .cw_data_en(cw_data_en), .cw_data(cw_data),
    .b_idx(b_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
    .sw_en(sw_en), .sw_st(sw_st)
  );

  mcc_snoop_ctl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ID_W(ID_W), .MY_ID(MY_ID)
  ) u_snoop (
    .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_id(snp_id),
    .b_idx(b_idx), .b_st(b_st), .b_tag(b_tag),
    .active(snp_active), .match(snp_match),
    .sw_en(sw_en), .sw_st(sw_st), .wb_req(snp_wb)
  );

  mcc_req_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .MESI_EN(MESI_EN)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rdata(cpu_rdata),
    .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
    .cw_st_en(cw_st_en), .cw_st(cw_st), .cw_tag_en(cw_tag_en), .cw_tag(cw_tag),
    .cw_data_en(cw_data_en), .cw_data(cw_data),
    .snp_active(snp_active),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(cmd_out),
    .fill_valid(fill_valid), .fill_data(fill_data), .fill_shared(fill_shared),
    .evict_wb(evict_wb), .evict_addr(evict_addr)
  );

  assign bus_cmd        = cmd_out;
  assign bus_addr       = cpu_req_addr;
  assign bus_id         = ID_W'(MY_ID);
  assign snp_hit_shared = snp_match;

  // snoop-forced write-back and eviction share one strobe
  assign wb_valid = snp_wb | evict_wb;
  assign wb_addr  = snp_wb ? snp_addr : evict_addr;
  assign wb_data  = snp_wb ? b_data   : a_data;

  // R11: no processor request is taken while a foreign snoop is present
  assert_snoop_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    snp_active |-> !cpu_req_ready);

  // R7: eviction never collides with a snoop write-back
  assert_single_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_wb && evict_wb));

  // R10: a snooped invalidation leaves no dirty data behind without a write-back
  assert_dirty_kill_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_match && b_st == LS_M && snp_cmd != 2'b00) |-> wb_valid);
endmodule

// File: tb/tb_mcc_cache_ctrl.sv
`timescale 1ns/1ps
module tb_mcc_cache_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [1:0] C_RM = 2'b01, C_WM = 2'b10, C_INV = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          cpu_req_valid = 0, cpu_req_ready, cpu_req_write = 0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0, cpu_rdata;
  logic          bus_req, bus_gnt = 0;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_id;
  logic          fill_valid = 0, fill_shared = 1;
  logic [DW-1:0] fill_data = '0;
  logic [1:0]    snp_cmd = 2'b00, snp_id = 2'd0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_hit_shared, wb_valid;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;

  mcc_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(4), .ID_W(2), .MY_ID(1), .MESI_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_id(bus_id),
    .fill_valid(fill_valid), .fill_data(fill_data), .fill_shared(fill_shared),
    .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_id(snp_id),
    .snp_hit_shared(snp_hit_shared),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  int checks = 0, failures = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bus and memory model state
  logic [DW-1:0] mem [256];
  logic          share_mode = 1;
  int            gnt_delay = 0, req_wait = 0, fill_cnt = 0;
  logic [AW-1:0] fill_addr = '0;
  int            cmd_count = 0, wb_count = 0, cmd_time = 0, wb_time = 0;
  logic [1:0]    last_cmd = 0, last_id = 0;
  logic [AW-1:0] last_addr = 0, last_wb_addr = 0;
  logic [DW-1:0] last_wb_data = 0;
  logic          was_waiting = 0, req_drop = 0, cmd_stray = 0;

  function automatic logic [DW-1:0] memv(input logic [AW-1:0] a);
    return 16'hA000 ^ (16'(a) * 16'd37);
  endfunction

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = memv(8'(i));
    forever begin
      @(negedge clk);
      fill_valid = 0;
      if (fill_cnt > 0) begin
        fill_cnt--;
        if (fill_cnt == 0) begin
          fill_valid = 1; fill_data = mem[fill_addr]; fill_shared = share_mode;
        end
      end
      if (bus_req) begin
        bus_gnt = (req_wait >= gnt_delay);
        req_wait++;
      end else begin
        bus_gnt = 0; req_wait = 0;
      end
      #2;
      if (was_waiting && !bus_req) req_drop = 1;
      was_waiting = bus_req && !bus_gnt;
      if (bus_cmd != 2'b00) begin
        if (!bus_gnt) cmd_stray = 1;
        cmd_count++; last_cmd = bus_cmd; last_addr = bus_addr; last_id = bus_id; cmd_time = cyc;
        if (bus_cmd != C_INV) begin fill_cnt = 2; fill_addr = bus_addr; end
      end
      if (wb_valid) begin
        mem[wb_addr] = wb_data; wb_count++; last_wb_addr = wb_addr;
        last_wb_data = wb_data; wb_time = cyc;
      end
    end
  end

  task automatic cpu_op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int waited);
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_write = w; cpu_req_addr = a; cpu_req_wdata = d;
    waited = 0;
    #4;
    while (!cpu_req_ready && waited < 1000) begin
      @(negedge clk); #4; waited++;
    end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_req_valid = 0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input logic [1:0] id,
                       output logic sh, output logic wv, output logic [DW-1:0] wd);
    @(negedge clk);
    snp_cmd = c; snp_addr = a; snp_id = id;
    #3;
    sh = snp_hit_shared; wv = wb_valid; wd = wb_data;
    @(posedge clk); #1;
    snp_cmd = 2'b00;
  endtask

  logic [DW-1:0] rd, wd;
  logic          sh, wv;
  int            wt, c0, w0;

  task automatic t_reset();
    check_eq("R1 bus_req low after reset", 32'(bus_req), 0);
    check_eq("R1 no write-back after reset", 32'(wb_valid), 0);
    snoop(C_RM, 8'h04, 2'd2, sh, wv, wd);
    check_eq("R1 snoop finds no copy", 32'(sh), 0);
  endtask

  task automatic t_read_miss();
    c0 = cmd_count;
    cpu_op(0, 8'h04, 0, rd, wt);
    check_eq("R1 first access misses", 32'(cmd_count - c0), 1);
    check_eq("R3 read-miss code", 32'(last_cmd), 32'(C_RM));
    check_eq("R3 miss address", 32'(last_addr), 32'h04);
    check_eq("R3 requester id", 32'(last_id), 1);
    check_eq("R3 fill data returned", 32'(rd), 32'(memv(8'h04)));
  endtask

  task automatic t_read_hit();
    c0 = cmd_count;
    cpu_op(0, 8'h04, 0, rd, wt);
    check_eq("R2 hit accepted at once", 32'(wt), 0);
    check_eq("R2 hit data", 32'(rd), 32'(memv(8'h04)));
    check_eq("R2 no bus command", 32'(cmd_count - c0), 0);
  endtask

  task automatic t_upgrade();
    c0 = cmd_count;
    cpu_op(1, 8'h04, 16'h1234, rd, wt);
    check_eq("R4 one command", 32'(cmd_count - c0), 1);
    check_eq("R4 invalidate code", 32'(last_cmd), 32'(C_INV));
    cpu_op(0, 8'h04, 0, rd, wt);
    check_eq("R4 written data", 32'(rd), 32'h1234);
  endtask

  task automatic t_write_hit_m();
    c0 = cmd_count; w0 = wb_count;
    cpu_op(1, 8'h04, 16'h5678, rd, wt);
    check_eq("R5 accepted at once", 32'(wt), 0);
    check_eq("R5 no bus command", 32'(cmd_count - c0), 0);
    check_eq("R5 no write-back", 32'(wb_count - w0), 0);
    cpu_op(0, 8'h04, 0, rd, wt);
    check_eq("R5 data", 32'(rd), 32'h5678);
  endtask

  task automatic t_snoop_rm_m();
    snoop(C_RM, 8'h04, 2'd2, sh, wv, wd);
    check_eq("R8 write-back strobe", 32'(wv), 1);
    check_eq("R8 write-back data", 32'(wd), 32'h5678);
    check_eq("R9 shared response", 32'(sh), 1);
    c0 = cmd_count;
    cpu_op(1, 8'h04, 16'h9999, rd, wt);
    check_eq("R8 line left Shared: write upgrades", 32'(last_cmd), 32'(C_INV));
    check_eq("R8 one upgrade command", 32'(cmd_count - c0), 1);
  endtask

  task automatic t_snoop_wm_m();
    snoop(C_WM, 8'h04, 2'd2, sh, wv, wd);
    check_eq("R10 write-miss on dirty writes back", 32'(wv), 1);
    check_eq("R10 write-back data", 32'(wd), 32'h9999);
    c0 = cmd_count;
    cpu_op(0, 8'h04, 0, rd, wt);
    check_eq("R10 line invalid: read misses", 32'(cmd_count - c0), 1);
    check_eq("R10 memory got dirty word", 32'(rd), 32'h9999);
  endtask

  task automatic t_snoop_rm_s();
    snoop(C_RM, 8'h04, 2'd2, sh, wv, wd);
    check_eq("R9 shared response on clean line", 32'(sh), 1);
    check_eq("R9 no write-back", 32'(wv), 0);
    c0 = cmd_count;
    cpu_op(0, 8'h04, 0, rd, wt);
    check_eq("R9 line still valid", 32'(cmd_count - c0), 0);
  endtask

  task automatic t_snoop_inv_s();
    snoop(C_INV, 8'h04, 2'd2, sh, wv, wd);
    check_eq("R10 invalidate on clean: no write-back", 32'(wv), 0);
    c0 = cmd_count;
    cpu_op(0, 8'h04, 0, rd, wt);
    check_eq("R10 invalidated line misses", 32'(cmd_count - c0), 1);
  endtask

  task automatic t_write_miss();
    c0 = cmd_count;
    cpu_op(1, 8'h09, 16'hBEEF, rd, wt);
    check_eq("R6 write-miss code", 32'(last_cmd), 32'(C_WM));
    check_eq("R6 write-miss address", 32'(last_addr), 32'h09);
    c0 = cmd_count;
    cpu_op(0, 8'h09, 0, rd, wt);
    check_eq("R6 written word kept", 32'(rd), 32'hBEEF);
    check_eq("R6 line Modified: no bus command", 32'(cmd_count - c0), 0);
  endtask

  task automatic t_evict();
    w0 = wb_count;
    cpu_op(0, 8'h0D, 0, rd, wt);
    check_eq("R7 one write-back", 32'(wb_count - w0), 1);
    check_eq("R7 victim address", 32'(last_wb_addr), 32'h09);
    check_eq("R7 victim data", 32'(last_wb_data), 32'hBEEF);
    check_eq("R7 write-back before command", 32'(wb_time < cmd_time), 1);
    check_eq("R7 new line data", 32'(rd), 32'(memv(8'h0D)));
    w0 = wb_count;
    cpu_op(0, 8'h09, 0, rd, wt);
    check_eq("R7 clean victim dropped silently", 32'(wb_count - w0), 0);
    check_eq("R7 refetched dirty word", 32'(rd), 32'hBEEF);
  endtask

  task automatic t_priority();
    snoop(C_INV, 8'h09, 2'd1, sh, wv, wd);
    check_eq("R11 own-id snoop ignored", 32'(sh), 0);
    c0 = cmd_count;
    cpu_op(0, 8'h09, 0, rd, wt);
    check_eq("R11 line survives own-id snoop", 32'(cmd_count - c0), 0);
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_write = 0; cpu_req_addr = 8'h09;
    snp_cmd = C_RM; snp_addr = 8'h22; snp_id = 2'd2;
    #4;
    check_eq("R11 stalled during snoop", 32'(cpu_req_ready), 0);
    @(posedge clk); #1;
    snp_cmd = 2'b00;
    @(negedge clk); #4;
    check_eq("R11 accepted after snoop", 32'(cpu_req_ready), 1);
    check_eq("R11 data after snoop", 32'(cpu_rdata), 32'hBEEF);
    @(posedge clk); #1;
    cpu_req_valid = 0;
  endtask

  task automatic t_mesi();
    share_mode = 0;
    cpu_op(0, 8'h0E, 0, rd, wt);
    c0 = cmd_count;
    cpu_op(1, 8'h0E, 16'h4444, rd, wt);
    check_eq("R12 silent upgrade from Exclusive", 32'(cmd_count - c0), 0);
    snoop(C_RM, 8'h0E, 2'd2, sh, wv, wd);
    check_eq("R12 now Modified: write-back", 32'(wv), 1);
    check_eq("R12 write-back data", 32'(wd), 32'h4444);
    cpu_op(0, 8'h0F, 0, rd, wt);
    snoop(C_RM, 8'h0F, 2'd2, sh, wv, wd);
    check_eq("R12 Exclusive snooped: no write-back", 32'(wv), 0);
    check_eq("R12 Exclusive reports copy", 32'(sh), 1);
    c0 = cmd_count;
    cpu_op(1, 8'h0F, 16'h7777, rd, wt);
    check_eq("R12 downgraded to Shared: invalidate", 32'(last_cmd), 32'(C_INV));
    share_mode = 1;
  endtask

  task automatic t_bus_hold();
    gnt_delay = 4; req_drop = 0;
    c0 = cmd_count;
    cpu_op(0, 8'h11, 0, rd, wt);
    check_eq("R13 request held until grant", 32'(req_drop), 0);
    check_eq("R13 waited for delayed grant", 32'(wt >= 4), 1);
    check_eq("R13 command after grant", 32'(last_cmd), 32'(C_RM));
    check_eq("R13 fill data", 32'(rd), 32'(memv(8'h11)));
    check_eq("R13 no command outside grant", 32'(cmd_stray), 0);
    gnt_delay = 0;
  endtask

  logic done = 0;
  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #3;
    t_reset();
    t_read_miss();
    t_read_hit();
    t_upgrade();
    t_write_hit_m();
    t_snoop_rm_m();
    t_snoop_wm_m();
    t_snoop_rm_s();
    t_snoop_inv_s();
    t_write_miss();
    t_evict();
    t_priority();
    t_mesi();
    t_bus_hold();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule